// File: doc/BRIEF.md
# Paged Memory Address Translator

This block sits between an 8-bit processor's 16-bit address bus and a larger static RAM. It widens each memory cycle's address to a 20-bit physical address. The 64 KB logical space is cut into sixteen 4 KB pages. Each page has an 8-bit bank register that supplies the upper physical address bits. Software reprograms the map by writing to the last sixteen byte addresses of the logical space. These locations sit underneath the fixed ROM window, so they cannot be read back: a read there returns ROM data.

Only RAM cycles go through the map. The I/O window at $8000-$9FFF and the ROM window at $E000-$FFFF always present their logical address, zero-extended to 20 bits. The block also decodes the three chip selects.

The RAM is 256 KB built from a 16-bit-wide SRAM. Physical bit 17 picks the data lane that carries the byte, and the remaining low bits form the SRAM word address. All outputs are combinational from the current bus inputs and the register contents. A map write lands on the clock edge that closes the write cycle.

Top module: `pmt_translator`

## Requirements
- R1: After reset, page register n holds the value n, so a RAM access to logical page n drives phys_addr[19:12] = n.
- R2: A cycle with mem_valid=1, cpu_rnw=0 and cpu_addr in $FFF0-$FFFF loads register cpu_addr[3:0] with cpu_wdata at the rising clock edge that ends the cycle. From the next cycle on, a RAM access to that page drives phys_addr[19:12] equal to the written byte.
- R3: For every cycle, phys_addr[11:0] equals cpu_addr[11:0].
- R4: The page registers ignore reads in $FFF0-$FFFF and ignore cycles with mem_valid=0. Such cycles leave every later translation unchanged, and a read in that range asserts rom_sel.
- R5: io_sel is 1 exactly when mem_valid=1 and cpu_addr is in $8000-$9FFF. During such a cycle phys_addr is {4'h0, cpu_addr}.
- R6: rom_sel is 1 exactly when mem_valid=1, cpu_rnw=1 and cpu_addr is in $E000-$FFFF, with phys_addr = {4'h0, cpu_addr}. A write in that range asserts no chip select.
- R7: ram_sel is 1 exactly when mem_valid=1 and cpu_addr is outside both fixed windows. At most one of ram_sel, rom_sel and io_sel is 1, and none is 1 when mem_valid=0.
- R8: ram_wr is 1 exactly when ram_sel=1, cpu_rnw=0 and wr_phase=1.
- R9: During a RAM cycle, lane_lo=1 (data lines 7:0) when phys_addr[17]=0, and lane_hi=1 (data lines 15:8) when phys_addr[17]=1. Both lanes are 0 when ram_sel=0.
- R10: sram_addr equals phys_addr[16:0]. This is the 16-bit word index once the lane bit is removed; physical bits 19:18 alias onto the installed 256 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; map writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; loads the identity map |
| cpu_addr | input | 16 | Logical byte address from the processor |
| cpu_wdata | input | 8 | Processor write data, used for map writes |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| mem_valid | input | 1 | 1 when the current cycle is a real memory access |
| wr_phase | input | 1 | Clock phase in which RAM writes may strobe |
| phys_addr | output | 20 | Physical byte address |
| sram_addr | output | 17 | SRAM word address |
| ram_sel | output | 1 | RAM chip select |
| ram_wr | output | 1 | RAM write enable, qualified by wr_phase |
| rom_sel | output | 1 | ROM chip select |
| io_sel | output | 1 | I/O window select |
| lane_lo | output | 1 | Byte travels on SRAM data lines 7:0 |
| lane_hi | output | 1 | Byte travels on SRAM data lines 15:8 |

## Verification
The assertions check these rules in every cycle:
- the offset pass-through;
- the exclusivity of the chip selects and their dependence on mem_valid;
- the lane choice from physical bit 17;
- the phase-qualified write enable;
- the zero-extended address in the fixed windows;
- the rule that a map write shows up in the next access to that page.

Some behaviours only the bench's scenarios can show, because they depend on register history over many cycles:
- the identity map right after reset;
- that a read of the map range, or a write with mem_valid=0, leaves the bank registers untouched;
- that programmed banks persist across unrelated traffic.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_IO   = 2'd2,
    RGN_ROM  = 2'd3
  } region_e;
endpackage

// File: rtl/pmt_page_file.sv
`timescale 1ns/1ps
module pmt_page_file #(
  parameter int PAGE_W = 4,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [BANK_W-1:0] rd_bank
);
  localparam int NUM_PAGES = 1 << PAGE_W;

  logic [BANK_W-1:0] bank_q [NUM_PAGES];

  // One register per page; reset value makes the map an identity map.
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[g] <= BANK_W'(g);
      else if (wr_en && wr_idx == PAGE_W'(g))
        bank_q[g] <= wr_bank;
    end
  end

  assign rd_bank = bank_q[rd_idx];
endmodule

// File: rtl/pmt_region_decode.sv
`timescale 1ns/1ps
module pmt_region_decode
  import pmt_pkg::*;
#(
  parameter int                 LADDR_W  = 16,
  parameter int                 PAGE_W   = 4,
  parameter logic [LADDR_W-1:0] IO_BASE  = 16'h8000,
  parameter logic [LADDR_W-1:0] IO_LAST  = 16'h9FFF,
  parameter logic [LADDR_W-1:0] ROM_BASE = 16'hE000
) (
  input  logic [LADDR_W-1:0] addr,
  input  logic               rnw,
  input  logic               valid,
  output region_e            region,
  output logic               map_wr
);
  localparam logic [LADDR_W-1:0] MAP_BASE = {LADDR_W{1'b1}} << PAGE_W;

  logic in_io, in_rom;

  assign in_io  = (addr >= IO_BASE) && (addr <= IO_LAST);
  assign in_rom = (addr >= ROM_BASE);
  assign map_wr = valid && !rnw && (addr >= MAP_BASE);

  always_comb begin
    if (!valid)      region = RGN_NONE;
    else if (in_io)  region = RGN_IO;
    else if (in_rom) region = rnw ? RGN_ROM : RGN_NONE;
    else             region = RGN_RAM;
  end
endmodule

// File: rtl/pmt_lane_steer.sv
`timescale 1ns/1ps
module pmt_lane_steer #(
  parameter int RAM_AW = 18
) (
  input  logic [RAM_AW-1:0] ram_byte_addr,
  input  logic              ram_sel,
  input  logic              rnw,
  input  logic              wr_phase,
  output logic [RAM_AW-2:0] sram_addr,
  output logic              lane_lo,
  output logic              lane_hi,
  output logic              ram_wr
);
  logic lane_bit;

  // Top bit of the installed range picks the half of the 16-bit bus.
  assign lane_bit  = ram_byte_addr[RAM_AW-1];
  assign sram_addr = ram_byte_addr[RAM_AW-2:0];
  assign lane_lo   = ram_sel && !lane_bit;
  assign lane_hi   = ram_sel &&  lane_bit;
  assign ram_wr    = ram_sel && !rnw && wr_phase;
endmodule

// File: rtl/pmt_translator.sv
`timescale 1ns/1ps
module pmt_translator
  import pmt_pkg::*;
#(
  parameter int LADDR_W = 16,
  parameter int PAGE_W  = 4,
  parameter int BANK_W  = 8,
  parameter int RAM_AW  = 18,
  localparam int OFFS_W  = LADDR_W - PAGE_W,
  localparam int PHYS_W  = BANK_W + OFFS_W,
  localparam int SRAM_AW = RAM_AW - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0]  cpu_wdata,
  input  logic               cpu_rnw,
  input  logic               mem_valid,
  input  logic               wr_phase,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               ram_sel,
  output logic               ram_wr,
  output logic               rom_sel,
  output logic               io_sel,
  output logic               lane_lo,
  output logic               lane_hi
);
  region_e           region;
  logic              map_wr;
  logic [BANK_W-1:0] bank;

  pmt_region_decode #(.LADDR_W(LADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .addr   (cpu_addr),
    .rnw    (cpu_rnw),
    .valid  (mem_valid),
    .region (region),
    .map_wr (map_wr)
  );

  pmt_page_file #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_pages (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr),
    .wr_idx  (cpu_addr[PAGE_W-1:0]),
    .wr_bank (cpu_wdata),
    .rd_idx  (cpu_addr[LADDR_W-1 -: PAGE_W]),
    .rd_bank (bank)
  );

  assign ram_sel = (region == RGN_RAM);
  assign rom_sel = (region == RGN_ROM);
  assign io_sel  = (region == RGN_IO);

  // Fixed windows keep the logical address; only RAM is paged.
  assign phys_addr = ram_sel ? {bank, cpu_addr[OFFS_W-1:0]}
                             : PHYS_W'(cpu_addr);

  pmt_lane_steer #(.RAM_AW(RAM_AW)) u_lane (
    .ram_byte_addr (phys_addr[RAM_AW-1:0]),
    .ram_sel       (ram_sel),
    .rnw           (cpu_rnw),
    .wr_phase      (wr_phase),
    .sram_addr     (sram_addr),
    .lane_lo       (lane_lo),
    .lane_hi       (lane_hi),
    .ram_wr        (ram_wr)
  );
endmodule

// File: rtl/pmt_translator_chk.sv
`timescale 1ns/1ps
module pmt_translator_chk #(
  parameter int LADDR_W = 16,
  parameter int PAGE_W  = 4,
  parameter int BANK_W  = 8,
  parameter int RAM_AW  = 18,
  localparam int OFFS_W  = LADDR_W - PAGE_W,
  localparam int PHYS_W  = BANK_W + OFFS_W,
  localparam int SRAM_AW = RAM_AW - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LADDR_W-1:0] cpu_addr,
  input logic [BANK_W-1:0]  cpu_wdata,
  input logic               cpu_rnw,
  input logic               mem_valid,
  input logic               wr_phase,
  input logic [PHYS_W-1:0]  phys_addr,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               ram_sel,
  input logic               ram_wr,
  input logic               rom_sel,
  input logic               io_sel,
  input logic               lane_lo,
  input logic               lane_hi
);
  localparam logic [LADDR_W-1:0] MAP_LO = {LADDR_W{1'b1}} << PAGE_W;

  logic wr_seen;
  assign wr_seen = mem_valid && !cpu_rnw && (cpu_addr >= MAP_LO);

  assert_map_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_seen) && ram_sel &&
     cpu_addr[LADDR_W-1 -: PAGE_W] == $past(cpu_addr[PAGE_W-1:0]))
    |-> phys_addr[PHYS_W-1 -: BANK_W] == $past(cpu_wdata));

  assert_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

  assert_io_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (mem_valid && phys_addr == PHYS_W'(cpu_addr)));

  assert_rom_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (mem_valid && cpu_rnw && phys_addr == PHYS_W'(cpu_addr)));

  assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel, io_sel}));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !(ram_sel || rom_sel || io_sel));

  assert_write_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> (ram_sel && !cpu_rnw && wr_phase));

  assert_lane_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> ($countones({lane_lo, lane_hi}) == 1 &&
                 lane_hi == phys_addr[RAM_AW-1]));

  assert_lane_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> !(lane_lo || lane_hi));

  assert_word_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sram_addr == phys_addr[SRAM_AW-1:0]);
endmodule

bind pmt_translator pmt_translator_chk #(
  .LADDR_W(LADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .RAM_AW(RAM_AW)
) u_chk (.*);

// File: tb/pmt_translator_tb.sv
`timescale 1ns/1ps
module pmt_translator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rnw = 1'b1;
  logic        mem_valid = 1'b0;
  logic        wr_phase = 1'b0;
  logic [19:0] phys_addr;
  logic [16:0] sram_addr;
  logic        ram_sel, ram_wr, rom_sel, io_sel, lane_lo, lane_hi;

  int checks = 0;
  int errors = 0;
  int bank_m [16];

  always #2 clk = ~clk;

  pmt_translator u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, cpu_addr, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, compare, then apply model update at rising edge.
  task automatic cyc(input int a, input int d, input bit rnw, input bit vld,
                     input bit ph, input string tag);
    int e_phys, io, rom, e_ram, e_rom, e_io;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_rnw = rnw;
    mem_valid = vld; wr_phase = ph;
    #1;
    io  = (a >= 'h8000 && a <= 'h9FFF);
    rom = (a >= 'hE000);
    e_io  = vld && io;
    e_rom = vld && rom && rnw;
    e_ram = vld && !io && !rom;
    e_phys = e_ram ? (bank_m[a / 4096] * 4096 + a % 4096) : a;
    chk({tag, " R3 phys"}, int'(phys_addr), e_phys);
    chk({tag, " R7 ram_sel"}, int'(ram_sel), e_ram);
    chk({tag, " R6 rom_sel"}, int'(rom_sel), e_rom);
    chk({tag, " R5 io_sel"}, int'(io_sel), e_io);
    chk({tag, " R8 ram_wr"}, int'(ram_wr), int'(e_ram && !rnw && ph));
    chk({tag, " R9 lane_lo"}, int'(lane_lo), int'(e_ram && (e_phys / 131072) % 2 == 0));
    chk({tag, " R9 lane_hi"}, int'(lane_hi), int'(e_ram && (e_phys / 131072) % 2 == 1));
    chk({tag, " R10 sram_addr"}, int'(sram_addr), e_phys % 131072);
    @(posedge clk);
    if (vld && !rnw && a >= 'hFFF0) bank_m[a % 16] = d % 256;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bank_m[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity map after reset
    for (int n = 0; n < 16; n++) cyc(n * 4096 + 'h123, 0, 1'b1, 1'b1, 1'b0, "R1");

    // R2: program each page, then access each page with varied offsets
    for (int n = 0; n < 16; n++) cyc('hFFF0 + n, (n * 37 + 5) % 256, 1'b0, 1'b1, 1'b1, "R2");
    for (int n = 0; n < 16; n++) cyc(n * 4096 + (n * 273) % 4096, 0, 1'b1, 1'b1, 1'b0, "R2");
    for (int n = 0; n < 16; n++) cyc(n * 4096 + 'hFFF, 0, 1'b0, 1'b1, 1'b1, "R3");

    // R4: reads of the map range and invalid writes leave the map alone
    cyc('hFFF3, 'hAA, 1'b1, 1'b1, 1'b0, "R4");
    cyc('hFFF3, 'hAA, 1'b0, 1'b0, 1'b1, "R4");
    cyc('h3456, 0, 1'b1, 1'b1, 1'b0, "R4");
    cyc('h3456, 0, 1'b0, 1'b0, 1'b1, "R4");

    // R5 and R6: fixed windows, including boundaries and ROM writes
    cyc('h7FFF, 0, 1'b1, 1'b1, 1'b0, "R5");
    cyc('h8000, 0, 1'b1, 1'b1, 1'b0, "R5");
    cyc('h9FFF, 0, 1'b0, 1'b1, 1'b1, "R5");
    cyc('hA000, 0, 1'b1, 1'b1, 1'b0, "R5");
    cyc('hDFFF, 0, 1'b1, 1'b1, 1'b0, "R6");
    cyc('hE000, 0, 1'b1, 1'b1, 1'b0, "R6");
    cyc('hE000, 0, 1'b0, 1'b1, 1'b1, "R6");

    // R8: write outside the strobe phase
    cyc('h1234, 0, 1'b0, 1'b1, 1'b0, "R8");
    cyc('h1234, 0, 1'b0, 1'b1, 1'b1, "R8");

    // R9: lane selection by bank bit 5 (physical bit 17)
    cyc('hFFF2, 'h20, 1'b0, 1'b1, 1'b1, "R9");
    cyc('h2001, 0, 1'b1, 1'b1, 1'b0, "R9");
    cyc('hFFF2, 'hDF, 1'b0, 1'b1, 1'b1, "R9");
    cyc('h2001, 0, 1'b1, 1'b1, 1'b0, "R9");

    // R7: random traffic mixing map writes and all regions
    for (int k = 0; k < 3000; k++) begin
      int a;
      a = ($urandom % 8 == 0) ? ('hFFF0 + $urandom % 16) : ($urandom % 65536);
      cyc(a, $urandom % 256, 1'($urandom), 1'($urandom % 4 != 0), 1'($urandom), "R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule